// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading translation descriptors from memory, one level after another. The granule is 4 KB. Every table holds 512 descriptors of 8 bytes each, so each level resolves 9 address bits. A plain configuration pin picks the walk depth. In 4-level mode the translated range is 48 bits wide and the walk starts at level 0. In 3-level mode the range is 39 bits wide and the walk starts at level 1. Bit 63 of the address selects one of two table roots: a low-half root, usually private to a process, and a high-half root, usually shared by the kernel.

A walk can end early on a block descriptor. A block at level 1 maps 1 GB and a block at level 2 maps 2 MB. Otherwise the walk ends at level 3 on a 4 KB page. A walk can also end with a fault: the address is out of range, a descriptor is invalid, or a descriptor has a form that is illegal at its level.

Requests enter on a valid/ready port and only one walk is in flight at a time. `req_ready` is high only while the block is idle, so a requester that holds `req_valid` simply waits. Descriptor reads leave on a valid/ready request channel. The memory keeps `mem_req_ready` low to stall, and the block then holds the address steady. The memory returns exactly one `mem_rsp_valid` pulse with the 64-bit descriptor for each accepted read. The result is presented on a valid/ready response port and is held unchanged until `rsp_ready` is seen.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, while `rsp_valid` and `mem_req_valid` are both 0.
- R2: The translated range is 48 bits wide when `cfg_four_level`=1 and 39 bits wide when it is 0. If the address bits from 63 down to the top bit of that range are not all equal, the block reads no descriptor. It then responds with `rsp_fault`=01, `rsp_level` equal to the start level, `rsp_pa`=0 and `rsp_size`=0.
- R3: The root table is `root_lo` when virtual address bit 63 is 0 and `root_hi` when it is 1. Bits [11:0] of the chosen root are ignored.
- R4: Each descriptor read uses the address {table base bits [47:12], idx, 3'b000}. At level L, idx is virtual address bits [12+9*(3-L)+8 : 12+9*(3-L)]. This means level 0 uses [47:39], level 1 uses [38:30], level 2 uses [29:21] and level 3 uses [20:12].
- R5: The first read is made at level 0 in 4-level mode and at level 1 in 3-level mode.
- R6: A descriptor with bit 0 = 0 ends the walk with `rsp_fault`=10 and `rsp_level` equal to the level where it was read.
- R7: At levels 0 to 2, a descriptor with bits [1:0]=11 is a table pointer. The walk moves to the next level, using descriptor bits [47:12] as the new table base.
- R8: A descriptor with bits [1:0]=01 at level 1 ends the walk with a 1 GB block: `rsp_pa` = {desc[47:30], va[29:0]}, `rsp_size`=2, `rsp_level`=1. The same form at level 2 gives a 2 MB block: `rsp_pa` = {desc[47:21], va[20:0]}, `rsp_size`=1, `rsp_level`=2.
- R9: A descriptor with bits [1:0]=01 at level 0 ends the walk with `rsp_fault`=10 and `rsp_level`=0.
- R10: At level 3, bits [1:0]=11 give a 4 KB page: `rsp_pa` = {desc[47:12], va[11:0]}, `rsp_size`=0, `rsp_level`=3, `rsp_fault`=00. Bits [1:0]=01 at level 3 give `rsp_fault`=10 with `rsp_level`=3.
- R11: Only one walk is in flight at a time, and `req_ready` is high only when neither a read request nor a response is pending. The response fields and `rsp_valid` are held steady while `rsp_ready` is 0. The read address and `mem_req_valid` are held steady while `mem_req_ready` is 0.
- R12: Every faulting response carries `rsp_pa`=0 and `rsp_size`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_four_level | input | 1 | 1 selects a 4-level (48-bit) walk, 0 selects a 3-level (39-bit) walk; sampled when a request is accepted |
| root_lo | input | 48 | Root table address used when address bit 63 is 0 |
| root_hi | input | 48 | Root table address used when address bit 63 is 1 |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_va | input | 64 | Virtual address to translate |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data valid (one pulse per accepted read) |
| mem_rsp_data | input | 64 | Descriptor read from memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Requester accepts the result |
| rsp_pa | output | 48 | Physical address (0 on a fault) |
| rsp_size | output | 2 | Mapping size: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| rsp_fault | output | 2 | 00 = none, 01 = address out of range, 10 = translation fault |
| rsp_level | output | 2 | Level at which the walk ended |

## Verification
The bench drives an address with bit 40 set first in 3-level mode, where it must fault with no memory read, and then in 4-level mode, where it must walk. A design with a wrong range width would either read memory on a bad address or refuse a good one. Block descriptors are placed at level 0, level 1, level 2 and level 3. The test expects a fault, a 1 GB result, a 2 MB result and a fault respectively, so a decoder that ignores the level would return a wrong size or a page where a fault belongs. High-half walks in both modes check that bit 63 steers the root. A walk in 3-level mode on a large index checks that the first index is taken from bits [38:30] and not [47:39]. Random memory stalls and a response held for several cycles would expose any address or result that moves before its handshake.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  localparam int OFS_W   = 12;           // byte offset inside a 4 KB granule
  localparam int IDX_W   = 9;            // index bits resolved per level
  localparam int MAX_LVL = 4;            // deepest walk
  localparam int LAST_LVL = MAX_LVL - 1;
  localparam int LVL_W   = $clog2(MAX_LVL);
  localparam int DESC_W  = 64;
  localparam int VA_W    = 64;
  localparam int VA_FULL = OFS_W + IDX_W * MAX_LVL;        // 48-bit range
  localparam int VA_SHORT = VA_FULL - IDX_W;               // 39-bit range

  typedef enum logic [1:0] {
    ACT_TABLE = 2'd0,
    ACT_LEAF  = 2'd1,
    ACT_FAULT = 2'd2
  } ptw_act_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } ptw_state_e;

  localparam logic [1:0] FLT_NONE  = 2'b00;
  localparam logic [1:0] FLT_RANGE = 2'b01;
  localparam logic [1:0] FLT_XLAT  = 2'b10;
endpackage

// File: rtl/ptw_range_chk.sv
`timescale 1ns/1ps
module ptw_range_chk
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]  va,
  input  logic             four_level,
  output logic             in_range,
  output logic             use_high,
  output logic [LVL_W-1:0] start_lvl
);
  logic [1:0] ok_v;

  // One sign-extension check per supported range width.
  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int W = VA_FULL - g * IDX_W;
    logic [VA_W-W:0] top;
    assign top     = va[VA_W-1:W-1];
    assign ok_v[g] = (&top) | ~(|top);
  end

  assign in_range  = four_level ? ok_v[0] : ok_v[1];
  assign use_high  = va[VA_W-1];
  assign start_lvl = four_level ? LVL_W'(0) : LVL_W'(1);

  logic unused_va;
  assign unused_va = ^va[VA_SHORT-2:0];
endmodule

// File: rtl/ptw_index_mux.sv
`timescale 1ns/1ps
module ptw_index_mux
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int l = 0; l < MAX_LVL; l++) begin
      if (lvl == l[LVL_W-1:0])
        idx = va[OFS_W + IDX_W*(LAST_LVL-l) +: IDX_W];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{va[VA_W-1:VA_FULL], va[OFS_W-1:0]};
endmodule

// File: rtl/ptw_desc_dec.sv
`timescale 1ns/1ps
module ptw_desc_dec
  import ptw_pkg::*;
#(
  parameter int PA_W = 48
)(
  input  logic [DESC_W-1:0]     desc,
  input  logic [LVL_W-1:0]      lvl,
  input  logic [PA_W-1:0]       va_lo,
  output ptw_act_e              act,
  output logic [PA_W-1:0]       leaf_pa,
  output logic [1:0]            leaf_size,
  output logic [PA_W-OFS_W-1:0] next_base
);
  logic is_last, leaf_ok;
  logic [PA_W-1:0] keep_mask;

  assign is_last   = (lvl == LVL_W'(LAST_LVL));
  assign next_base = desc[PA_W-1:OFS_W];

  // A leaf is a page at the last level or a block at a middle level.
  assign leaf_ok = is_last ? desc[1] : (!desc[1] && lvl != '0);

  always_comb begin
    keep_mask = '1;
    for (int l = 0; l < MAX_LVL; l++) begin
      if (lvl == l[LVL_W-1:0])
        keep_mask = {PA_W{1'b1}} << (OFS_W + IDX_W*(LAST_LVL-l));
    end
  end

  always_comb begin
    leaf_pa   = (desc[PA_W-1:0] & keep_mask) | (va_lo & ~keep_mask);
    leaf_size = 2'(LVL_W'(LAST_LVL) - lvl);
    if (!desc[0])                  act = ACT_FAULT;
    else if (!is_last && desc[1])  act = ACT_TABLE;
    else if (leaf_ok)              act = ACT_LEAF;
    else                           act = ACT_FAULT;
  end

  // R10: a leaf at the last level always keeps the page offset untouched
  always_comb begin
    if (act == ACT_LEAF && is_last)
      a_r10_page_offset: assert (leaf_pa[OFS_W-1:0] == va_lo[OFS_W-1:0]);
  end

  logic unused_desc;
  assign unused_desc = ^{desc[DESC_W-1:PA_W], desc[OFS_W-1:2]};
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W = 48
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_four_level,
  input  logic [PA_W-1:0]   root_lo,
  input  logic [PA_W-1:0]   root_hi,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_va,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_size,
  output logic [1:0]        rsp_fault,
  output logic [1:0]        rsp_level
);
  localparam int BASE_W = PA_W - OFS_W;

  ptw_state_e         state_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [BASE_W-1:0]  base_q;
  logic [VA_W-1:0]    va_q;
  logic [PA_W-1:0]    pa_q;
  logic [1:0]         size_q, fault_q;
  logic [LVL_W-1:0]   end_lvl_q;

  logic               in_range, use_high;
  logic [LVL_W-1:0]   start_lvl;
  logic [IDX_W-1:0]   idx;
  ptw_act_e           act;
  logic [PA_W-1:0]    leaf_pa;
  logic [1:0]         leaf_size;
  logic [BASE_W-1:0]  next_base;

  ptw_range_chk u_range (
    .va        (req_va),
    .four_level(cfg_four_level),
    .in_range  (in_range),
    .use_high  (use_high),
    .start_lvl (start_lvl)
  );

  ptw_index_mux u_idx (
    .va (va_q),
    .lvl(lvl_q),
    .idx(idx)
  );

  ptw_desc_dec #(.PA_W(PA_W)) u_dec (
    .desc     (mem_rsp_data),
    .lvl      (lvl_q),
    .va_lo    (va_q[PA_W-1:0]),
    .act      (act),
    .leaf_pa  (leaf_pa),
    .leaf_size(leaf_size),
    .next_base(next_base)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_FETCH);
  assign mem_req_addr  = {base_q, idx, 3'b000};
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_size      = size_q;
  assign rsp_fault     = fault_q;
  assign rsp_level     = 2'(end_lvl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lvl_q     <= '0;
      base_q    <= '0;
      va_q      <= '0;
      pa_q      <= '0;
      size_q    <= '0;
      fault_q   <= FLT_NONE;
      end_lvl_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q  <= req_va;
          lvl_q <= start_lvl;
          if (!in_range) begin
            pa_q      <= '0;
            size_q    <= '0;
            fault_q   <= FLT_RANGE;
            end_lvl_q <= start_lvl;
            state_q   <= ST_RESP;
          end else begin
            base_q  <= use_high ? root_hi[PA_W-1:OFS_W] : root_lo[PA_W-1:OFS_W];
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          case (act)
            ACT_TABLE: begin
              base_q  <= next_base;
              lvl_q   <= lvl_q + 1'b1;
              state_q <= ST_FETCH;
            end
            ACT_LEAF: begin
              pa_q      <= leaf_pa;
              size_q    <= leaf_size;
              fault_q   <= FLT_NONE;
              end_lvl_q <= lvl_q;
              state_q   <= ST_RESP;
            end
            default: begin
              pa_q      <= '0;
              size_q    <= '0;
              fault_q   <= FLT_XLAT;
              end_lvl_q <= lvl_q;
              state_q   <= ST_RESP;
            end
          endcase
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11: result held while the requester stalls
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)
                                 && $stable(rsp_size) && $stable(rsp_level));

  // R11: read request held while memory stalls
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R11: a new request is taken only with nothing else pending
  a_r11_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !rsp_valid);

  // R12: faults carry no address and no size
  a_r12_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != FLT_NONE |-> rsp_pa == '0 && rsp_size == 2'd0);

  // R8: sizes are only 4 KB, 2 MB or 1 GB, and match the ending level
  a_r8_size_level: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == FLT_NONE |-> rsp_size != 2'd3 && rsp_level != 2'd0
                                           && (32'(rsp_size) + 32'(rsp_level) == LAST_LVL));

  // R2: an out-of-range request never reaches the memory port
  a_r2_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !in_range |=> !mem_req_valid);

  logic unused_root;
  assign unused_root = ^{root_lo[OFS_W-1:0], root_hi[OFS_W-1:0]};
endmodule

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  localparam logic [47:0] ROOT_LO = 48'h0000_0010_0000;
  localparam logic [47:0] ROOT_HI = 48'h0000_0020_0005; // low bits must be ignored (R3)

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_four_level = 1'b1;
  logic [47:0] root_lo = ROOT_LO, root_hi = ROOT_HI;
  logic        req_valid = 1'b0, req_ready;
  logic [63:0] req_va = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [47:0] rsp_pa;
  logic [1:0]  rsp_size, rsp_fault, rsp_level;

  ptw_walker dut_i (.*);

  always #2.5 clk = ~clk;

  int vectors = 0, misses = 0;
  bit finished = 1'b0;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- memory image ----------------
  logic [63:0] mem [logic [47:0]];

  function automatic logic [63:0] lookup(input logic [47:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic int idx_of(input logic [63:0] va, input int lvl);
    return int'((va >> (12 + 9*(3-lvl))) & 64'h1FF);
  endfunction

  function automatic void put_va(input logic [47:0] base, input logic [63:0] va,
                                 input int lvl, input logic [63:0] d);
    logic [47:0] b;
    b = {base[47:12], 12'h0};
    mem[b + 48'(idx_of(va, lvl) * 8)] = d;
  endfunction

  // ---------------- reference model ----------------
  logic [47:0] exp_addr_q[$];
  string       exp_atag_q[$];
  logic [47:0] exp_pa;
  logic [1:0]  exp_size, exp_fault, exp_lvl;
  string       exp_tag;
  bit          outst = 1'b0;

  function automatic void model(input logic [63:0] va, input bit four);
    int vaw, lvl, idx;
    bit ok, first;
    logic [47:0] base, a;
    logic [63:0] d;
    vaw = four ? 48 : 39;
    lvl = four ? 0 : 1;               // R5
    ok = 1'b1;
    for (int b = vaw - 1; b < 64; b++) if (va[b] != va[63]) ok = 1'b0;
    exp_pa = '0; exp_size = 2'd0; exp_fault = 2'b00; exp_lvl = 2'(lvl);
    if (!ok) begin exp_fault = 2'b01; exp_tag = "R2"; return; end
    base = va[63] ? root_hi : root_lo;
    base[11:0] = 12'h0;
    first = 1'b1;
    forever begin
      idx = idx_of(va, lvl);
      a = base + 48'(idx * 8);
      exp_addr_q.push_back(a);
      exp_atag_q.push_back(first ? "R4 R3 R5" : "R4 R7");
      first = 1'b0;
      d = lookup(a);
      exp_lvl = 2'(lvl);
      if (!d[0]) begin exp_fault = 2'b10; exp_tag = "R6"; return; end
      if (lvl == 3) begin
        exp_tag = "R10";
        if (d[1]) begin exp_pa = {d[47:12], va[11:0]}; exp_size = 2'd0; end
        else exp_fault = 2'b10;
        return;
      end
      if (d[1]) begin base = {d[47:12], 12'h0}; lvl++; continue; end
      if (lvl == 0) begin exp_fault = 2'b10; exp_tag = "R9"; return; end
      exp_tag = "R8";
      if (lvl == 1) begin exp_pa = {d[47:30], va[29:0]}; exp_size = 2'd2; end
      else          begin exp_pa = {d[47:21], va[20:0]}; exp_size = 2'd1; end
      return;
    end
  endfunction

  // ---------------- memory responder with random stalls ----------------
  logic [15:0] lfsr = 16'hACE1;
  bit          busy = 1'b0;
  int          lat = 0;
  logic [63:0] rd = '0;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready <= lfsr[0] | lfsr[3];
    mem_rsp_valid <= 1'b0;
    if (busy) begin
      if (lat == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= rd;
        busy          <= 1'b0;
      end else lat <= lat - 1;
    end else if (mem_req_valid && mem_req_ready) begin
      busy <= 1'b1;
      lat  <= int'(lfsr[1:0]);
      rd   <= lookup(mem_req_addr);
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(64'(req_ready), 64'(!outst), "R11 req_ready vs idle");
      if (mem_req_valid && mem_req_ready) begin
        if (exp_addr_q.size() == 0)
          chk(64'(mem_req_addr), 64'hDEAD, "R2 unexpected descriptor read");
        else
          chk(64'(mem_req_addr), 64'(exp_addr_q.pop_front()), exp_atag_q.pop_front());
      end
      if (rsp_valid) begin
        chk(64'(rsp_fault), 64'(exp_fault), {exp_tag, " fault"});
        chk(64'(rsp_level), 64'(exp_lvl),   {exp_tag, " level"});
        chk(64'(rsp_pa),    64'(exp_pa),    exp_fault != 0 ? "R12 pa" : {exp_tag, " pa"});
        chk(64'(rsp_size),  64'(exp_size),  exp_fault != 0 ? "R12 size" : {exp_tag, " size"});
        if (rsp_ready) begin
          chk(64'(exp_addr_q.size()), 64'd0, "R11 reads done before result");
          outst = 1'b0;
        end
      end
      if (req_valid && req_ready) begin
        model(req_va, cfg_four_level);
        outst = 1'b1;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic run(input logic [63:0] va, input bit four, input int hold);
    @(posedge clk); #1;
    cfg_four_level = four;
    req_va    = va;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (!rsp_valid) begin @(posedge clk); #1; end
    repeat (hold) @(posedge clk);   // R11: result must stay put meanwhile
    #1 rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [63:0] va1, va2, va3, va4, va5, va6, va7, va8;
    va1 = (64'd1 << 39) | (64'd2 << 30) | (64'd3 << 21) | (64'd4 << 12) | 64'hABC;
    va2 = (64'd1 << 39) | (64'd5 << 30) | 64'h1234_5678;
    va3 = (64'd1 << 39) | (64'd2 << 30) | (64'd7 << 21) | 64'h1_5555;
    va4 = (64'd1 << 39) | (64'd2 << 30) | (64'd8 << 21);
    va5 = 64'h0000_0100_0000_0000;          // bit 40: legal only in 4-level mode
    va6 = (64'd1 << 39) | (64'd2 << 30) | (64'd3 << 21) | (64'd5 << 12) | 64'h010;
    va7 = 64'hFFFF_FFC0_0000_0000 | (64'd3 << 30) | (64'd9 << 21) | (64'd6 << 12) | 64'h123;
    va8 = (64'd4 << 30) | (64'd1 << 21) | 64'h1_FFFF;

    // tables for the low-half 4-level walks
    put_va(ROOT_LO, va1, 0, 64'h30003);
    put_va(48'h30000, va1, 1, 64'h31003);
    put_va(48'h31000, va1, 2, 64'h32003);
    put_va(48'h32000, va1, 3, 64'h7777_7003);
    put_va(48'h30000, va2, 1, 64'hC000_0001);
    put_va(48'h31000, va3, 2, 64'h0060_0001);
    put_va(ROOT_LO, va5, 0, 64'h4000_0001);     // block at level 0
    put_va(48'h32000, va6, 3, 64'h0008_8001);   // bits[1:0]=01 at level 3
    // high-half 3-level walk
    put_va(ROOT_HI, va7, 1, 64'h50003);
    put_va(48'h50000, va7, 2, 64'h51003);
    put_va(48'h51000, va7, 3, 64'h0ABC_D003);
    // low-half 3-level walk ending on a 2 MB block
    put_va(ROOT_LO, va8, 1, 64'h60003);
    put_va(48'h60000, va8, 2, 64'h4000_0001);

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(64'(req_ready),     64'd1, "R1 req_ready after reset");
    chk(64'(rsp_valid),     64'd0, "R1 rsp_valid after reset");
    chk(64'(mem_req_valid), 64'd0, "R1 mem_req_valid after reset");

    run(va1, 1'b1, 0);   // R10 page through four levels, R7 table steps
    run(va2, 1'b1, 2);   // R8 1 GB block
    run(va3, 1'b1, 0);   // R8 2 MB block
    run(va4, 1'b1, 0);   // R6 invalid at level 2
    run(va5, 1'b0, 1);   // R2 out of 39-bit range, no read
    run(va5, 1'b1, 0);   // R9 block at level 0 (same address valid in 48-bit mode)
    run(va6, 1'b1, 0);   // R10 bad form at level 3
    run(va7, 1'b0, 3);   // R3 high root, R5 3-level start
    run(64'h8000_0000_0000_1000, 1'b1, 4);  // R2 mixed upper bits in 4-level mode
    run(64'hFFFF_8000_0000_0000, 1'b1, 0);  // R3 high root, R6 empty entry
    run(va8, 1'b0, 0);   // R5 3-level low half, R8 2 MB block
    run(va1, 1'b1, 1);   // repeat under different stall pattern

    repeat (4) @(posedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule